// File: doc/BRIEF.md
# Serial Flash Command Front-End

This block sits on the target side of a serial NOR flash bus. It oversamples the bus clock, the active-low chip select and four data lines in the system clock domain. It frames each command between a falling and a rising edge of chip select, and it assembles the opcode and up to four operand bytes, most significant bit first. In single-line mode each rising bus clock edge brings in one bit on data line 0. In four-line mode each edge brings in a nibble on all four lines, so a byte takes two clocks.

The block keeps the interface mode itself. It handles the mode-switch opcodes and the two-step software reset internally, and it does not forward them. Every other completed command reaches downstream logic as a single-cycle strobe that carries the opcode, the number of bits received and the captured operand bytes. Write-type commands are forwarded only when the frame length is a whole number of bytes. During the reset interval the block shows a busy flag and accepts no frame.

Top module: `flash_cmd_frontend`

## Requirements
- R1: After the synchronous reset, `cmd_valid`, `qpi_mode` and `reset_busy` are all 0.
- R2: After reset, a frame is accepted only once chip select has been seen high at least once. Bus clocks that arrive while chip select is still low from reset produce no command.
- R3: In single-line mode, each rising bus clock edge inside a frame shifts `bus_io[0]` in, MSB first. The first byte is the opcode. Operand byte k (k = 0..3) appears at `cmd_operands[8k+7:8k]`. Bytes beyond the fourth operand are counted but dropped. An operand byte that was not completely received reads as 0. `cmd_bits` gives the total number of bits received.
- R4: In four-line mode, each rising edge shifts in the nibble `bus_io[3:0]`, with `bus_io[3]` the most significant bit, and `cmd_bits` grows by 4 per clock.
- R5: The bus clock may idle low (mode 0) or high (mode 3) while chip select is high. Both give the same captured command.
- R6: Opcode 0x38 switches to four-line mode only if `quad_en` is 1 when the frame ends. Otherwise it has no effect. It is never forwarded.
- R7: Opcode 0xFF returns the block to single-line mode and is never forwarded.
- R8: The write-type opcodes 0x01, 0x02, 0x11, 0x20, 0x31, 0x32, 0x42, 0x44, 0x52, 0x60, 0xC7 and 0xD8 are forwarded only if `cmd_bits` is a multiple of 8. Any other opcode is forwarded at any length of 8 bits or more. The control opcodes (0x38, 0xFF, 0x66, 0x99) also act only at a multiple of 8 bits.
- R9: A software reset takes place only when 0x66 is followed directly by 0x99 as the next command of 8 bits or more. It sets `reset_busy` for exactly RESET_CYCLES system clocks and forces single-line mode. A 0x99 without a directly preceding 0x66 does nothing.
- R10: A frame whose chip select falls while `reset_busy` is 1 is ignored entirely.
- R11: `cmd_valid` is a one-cycle pulse, given once per accepted frame after chip select rises. A frame shorter than 8 bits produces nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cs_n | input | 1 | Bus chip select, active low |
| bus_sclk | input | 1 | Bus serial clock |
| bus_io | input | 4 | Bus data lines; line 0 is the single-line input |
| quad_en | input | 1 | Quad-enable configuration bit |
| qpi_mode | output | 1 | 1 when four-line mode is active |
| reset_busy | output | 1 | Software reset interval in progress |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_opcode | output | 8 | Opcode of the forwarded command |
| cmd_bits | output | BITS_W | Bits received in the frame, saturating |
| cmd_operands | output | 8*NUM_OPS | Operand bytes, byte 0 in the low bits |

## Verification
The checker watches on every cycle that the strobe lasts one cycle, and that no strobe appears during the reset interval. It also checks that a forwarded write-type opcode is byte-aligned and at least a byte long, that control opcodes never reach the output, and that four-line mode is entered only with the quad-enable bit set and never while reset is busy. Other behaviours need the bench's scenarios: the exact operand packing for each frame length, the sequence rule of the two-step reset and the exact length of its busy interval, the arming rule after reset, and the equal results in modes 0 and 3.

// File: rtl/flash_fe_pkg.sv
package flash_fe_pkg;

    localparam logic [7:0] OP_QPI_ON  = 8'h38;
    localparam logic [7:0] OP_QPI_OFF = 8'hFF;
    localparam logic [7:0] OP_RST_ARM = 8'h66;
    localparam logic [7:0] OP_RST_GO  = 8'h99;

    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_DROP,
        ACT_FWD,
        ACT_QPI_ON,
        ACT_QPI_OFF,
        ACT_RST_ARM,
        ACT_RST_GO
    } fe_action_e;

    function automatic logic is_write_op(input logic [7:0] op);
        case (op)
            8'h01, 8'h02, 8'h11, 8'h20, 8'h31, 8'h32,
            8'h42, 8'h44, 8'h52, 8'h60, 8'hC7, 8'hD8: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic is_ctrl_op(input logic [7:0] op);
        return (op == OP_QPI_ON) || (op == OP_QPI_OFF) ||
               (op == OP_RST_ARM) || (op == OP_RST_GO);
    endfunction

    // Decide what a finished frame does to the block state.
    function automatic fe_action_e decide(input logic [7:0] op,
                                          input logic      long_enough,
                                          input logic      aligned,
                                          input logic      qe,
                                          input logic      rst_armed);
        if (!long_enough)          return ACT_NONE;
        if (is_ctrl_op(op)) begin
            if (!aligned)          return ACT_DROP;
            case (op)
                OP_QPI_ON:  return qe ? ACT_QPI_ON : ACT_DROP;
                OP_QPI_OFF: return ACT_QPI_OFF;
                OP_RST_ARM: return ACT_RST_ARM;
                default:    return rst_armed ? ACT_RST_GO : ACT_DROP;
            endcase
        end
        if (is_write_op(op) && !aligned) return ACT_DROP;
        return ACT_FWD;
    endfunction

endpackage

// File: rtl/flash_fe_sync.sv
module flash_fe_sync #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage <= '0;
            q     <= '0;
        end else begin
            stage <= d;
            q     <= stage;
        end
    end
endmodule

// File: rtl/flash_fe_shifter.sv
module flash_fe_shifter #(
    parameter int BITS_W   = 8,
    parameter int NUM_OPS  = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cs_n,
    input  logic                     sclk,
    input  logic [3:0]               io,
    input  logic                     qpi,
    input  logic                     hold_off,
    output logic                     frame_end,
    output logic [7:0]               fr_opcode,
    output logic [BITS_W-1:0]        fr_bits,
    output logic [NUM_OPS-1:0][7:0]  fr_ops
);
    localparam int IDX_W = BITS_W - 3;
    localparam logic [BITS_W-1:0] BITS_MAX = '1;

    logic              cs_q, sclk_q, armed, active;
    logic [7:0]        sh, sh_next;
    logic [BITS_W-1:0] step, cnt_next;
    logic [IDX_W-1:0]  idx;

    wire cs_fall   = !cs_n && cs_q;
    wire cs_rise   = cs_n && !cs_q;
    wire sclk_rise = sclk && !sclk_q;

    always_comb begin
        step     = qpi ? BITS_W'(4) : BITS_W'(1);
        sh_next  = qpi ? {sh[3:0], io} : {sh[6:0], io[0]};
        cnt_next = (fr_bits > BITS_MAX - step) ? fr_bits : fr_bits + step;
        idx      = cnt_next[BITS_W-1:3];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q      <= 1'b0;
            sclk_q    <= 1'b0;
            armed     <= 1'b0;
            active    <= 1'b0;
            frame_end <= 1'b0;
            sh        <= '0;
            fr_bits   <= '0;
            fr_opcode <= '0;
            fr_ops    <= '0;
        end else begin
            cs_q      <= cs_n;
            sclk_q    <= sclk;
            frame_end <= 1'b0;
            if (cs_n) armed <= 1'b1;
            if (cs_fall && armed && !hold_off) begin
                active    <= 1'b1;
                sh        <= '0;
                fr_bits   <= '0;
                fr_opcode <= '0;
                fr_ops    <= '0;
            end else if (active && cs_rise) begin
                active    <= 1'b0;
                frame_end <= 1'b1;
            end else if (active && !cs_n && sclk_rise) begin
                sh      <= sh_next;
                fr_bits <= cnt_next;
                if (cnt_next != fr_bits && cnt_next[2:0] == 3'd0) begin
                    if (idx == IDX_W'(1)) fr_opcode <= sh_next;
                    for (int k = 0; k < NUM_OPS; k++)
                        if (idx == IDX_W'(k + 2)) fr_ops[k] <= sh_next;
                end
            end
        end
    end
endmodule

// File: rtl/flash_fe_ctrl.sv
module flash_fe_ctrl
    import flash_fe_pkg::*;
#(
    parameter int BITS_W       = 8,
    parameter int NUM_OPS      = 4,
    parameter int RESET_CYCLES = 64
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     frame_end,
    input  logic [7:0]               fr_opcode,
    input  logic [BITS_W-1:0]        fr_bits,
    input  logic [NUM_OPS-1:0][7:0]  fr_ops,
    input  logic                     quad_en,
    output logic                     qpi,
    output logic                     busy,
    output logic                     cmd_valid,
    output logic [7:0]               cmd_opcode,
    output logic [BITS_W-1:0]        cmd_bits,
    output logic [NUM_OPS-1:0][7:0]  cmd_ops
);
    localparam int CNT_W = $clog2(RESET_CYCLES + 1);

    logic [CNT_W-1:0] busy_cnt;
    logic             rst_armed;
    fe_action_e       act;

    assign busy = (busy_cnt != '0);
    assign act  = decide(fr_opcode, fr_bits >= BITS_W'(8),
                         fr_bits[2:0] == 3'd0, quad_en, rst_armed);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_cnt   <= '0;
            rst_armed  <= 1'b0;
            qpi        <= 1'b0;
            cmd_valid  <= 1'b0;
            cmd_opcode <= '0;
            cmd_bits   <= '0;
            cmd_ops    <= '0;
        end else begin
            cmd_valid <= 1'b0;
            if (busy) busy_cnt <= busy_cnt - 1'b1;
            if (frame_end && !busy && act != ACT_NONE) begin
                rst_armed <= (act == ACT_RST_ARM);
                case (act)
                    ACT_FWD: begin
                        cmd_valid  <= 1'b1;
                        cmd_opcode <= fr_opcode;
                        cmd_bits   <= fr_bits;
                        cmd_ops    <= fr_ops;
                    end
                    ACT_QPI_ON:  qpi <= 1'b1;
                    ACT_QPI_OFF: qpi <= 1'b0;
                    ACT_RST_GO: begin
                        qpi      <= 1'b0;
                        busy_cnt <= CNT_W'(RESET_CYCLES);
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/flash_cmd_frontend.sv
module flash_cmd_frontend #(
    parameter int BITS_W       = 8,
    parameter int NUM_OPS      = 4,
    parameter int RESET_CYCLES = 64
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   bus_cs_n,
    input  logic                   bus_sclk,
    input  logic [3:0]             bus_io,
    input  logic                   quad_en,
    output logic                   qpi_mode,
    output logic                   reset_busy,
    output logic                   cmd_valid,
    output logic [7:0]             cmd_opcode,
    output logic [BITS_W-1:0]      cmd_bits,
    output logic [8*NUM_OPS-1:0]   cmd_operands
);
    logic                    cs_s, sclk_s;
    logic [3:0]              io_s;
    logic                    frame_end;
    logic [7:0]              fr_opcode;
    logic [BITS_W-1:0]       fr_bits;
    logic [NUM_OPS-1:0][7:0] fr_ops, ops_q;

    flash_fe_sync #(.WIDTH(6)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({bus_cs_n, bus_sclk, bus_io}),
        .q   ({cs_s, sclk_s, io_s})
    );

    flash_fe_shifter #(.BITS_W(BITS_W), .NUM_OPS(NUM_OPS)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .cs_n      (cs_s),
        .sclk      (sclk_s),
        .io        (io_s),
        .qpi       (qpi_mode),
        .hold_off  (reset_busy),
        .frame_end (frame_end),
        .fr_opcode (fr_opcode),
        .fr_bits   (fr_bits),
        .fr_ops    (fr_ops)
    );

    flash_fe_ctrl #(.BITS_W(BITS_W), .NUM_OPS(NUM_OPS),
                    .RESET_CYCLES(RESET_CYCLES)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .frame_end  (frame_end),
        .fr_opcode  (fr_opcode),
        .fr_bits    (fr_bits),
        .fr_ops     (fr_ops),
        .quad_en    (quad_en),
        .qpi        (qpi_mode),
        .busy       (reset_busy),
        .cmd_valid  (cmd_valid),
        .cmd_opcode (cmd_opcode),
        .cmd_bits   (cmd_bits),
        .cmd_ops    (ops_q)
    );

    assign cmd_operands = ops_q;
endmodule

// File: rtl/flash_fe_chk.sv
module flash_fe_chk
    import flash_fe_pkg::*;
#(
    parameter int BITS_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              quad_en,
    input logic              qpi_mode,
    input logic              reset_busy,
    input logic              cmd_valid,
    input logic [7:0]        cmd_opcode,
    input logic [BITS_W-1:0] cmd_bits
);
    // R11
    strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> !cmd_valid);

    // R11
    strobe_min_len_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> cmd_bits >= BITS_W'(8));

    // R10
    busy_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        reset_busy |-> !cmd_valid);

    // R8
    write_aligned_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && is_write_op(cmd_opcode)) |-> cmd_bits[2:0] == 3'd0);

    // R8
    ctrl_hidden_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> !is_ctrl_op(cmd_opcode));

    // R6
    qpi_needs_qe_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(qpi_mode) |-> $past(quad_en));

    // R9
    busy_single_line_chk: assert property (@(posedge clk) disable iff (rst)
        reset_busy |-> !qpi_mode);
endmodule

bind flash_cmd_frontend flash_fe_chk #(.BITS_W(BITS_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .quad_en    (quad_en),
    .qpi_mode   (qpi_mode),
    .reset_busy (reset_busy),
    .cmd_valid  (cmd_valid),
    .cmd_opcode (cmd_opcode),
    .cmd_bits   (cmd_bits)
);

// File: tb/tb_flash_cmd_frontend.sv
module tb_flash_cmd_frontend;
    localparam int RST_CYC = 40;
    localparam int HALF    = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_cs_n = 1'b0;
    logic        bus_sclk = 1'b0;
    logic [3:0]  bus_io = 4'h0;
    logic        quad_en = 1'b0;
    logic        qpi_mode, reset_busy, cmd_valid;
    logic [7:0]  cmd_opcode, cmd_bits;
    logic [31:0] cmd_operands;

    int checks = 0;
    int errors = 0;
    int ncmd = 0;
    int busy_cycles = 0;
    logic [7:0]  m_op = '0;
    logic [7:0]  m_bits = '0;
    logic [31:0] m_ops = '0;

    always #5 clk = ~clk;

    flash_cmd_frontend #(.BITS_W(8), .NUM_OPS(4), .RESET_CYCLES(RST_CYC)) dut (
        .clk(clk), .rst(rst), .bus_cs_n(bus_cs_n), .bus_sclk(bus_sclk),
        .bus_io(bus_io), .quad_en(quad_en), .qpi_mode(qpi_mode),
        .reset_busy(reset_busy), .cmd_valid(cmd_valid), .cmd_opcode(cmd_opcode),
        .cmd_bits(cmd_bits), .cmd_operands(cmd_operands)
    );

    always @(negedge clk) begin
        if (cmd_valid) begin
            ncmd   <= ncmd + 1;
            m_op   <= cmd_opcode;
            m_bits <= cmd_bits;
            m_ops  <= cmd_operands;
        end
        if (reset_busy) busy_cycles <= busy_cycles + 1;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Send n bits of d (MSB first) in one frame.
    task automatic send(input logic [63:0] d, input int n, input bit q, input bit m3);
        int clocks;
        clocks = q ? n / 4 : n;
        bus_sclk = m3;
        wait_n(HALF);
        bus_cs_n = 1'b0;
        wait_n(HALF);
        for (int i = 0; i < clocks; i++) begin
            if (m3) bus_sclk = 1'b0;
            if (q) bus_io = d[63 - 4*i -: 4];
            else   bus_io = {3'b000, d[63 - i]};
            wait_n(HALF);
            bus_sclk = 1'b1;
            wait_n(HALF);
            if (!m3) bus_sclk = 1'b0;
        end
        wait_n(HALF);
        bus_cs_n = 1'b1;
        wait_n(12);
    endtask

    function automatic logic [63:0] pat(input logic [7:0] op);
        return {op, 8'h3C, 8'hA7, 8'h51, 8'hE2, 8'h9D, 16'h0000};
    endfunction

    function automatic logic [31:0] exp_ops(input logic [63:0] d, input int n);
        logic [31:0] r = '0;
        for (int k = 0; k < 4; k++)
            if (n >= 8 * (k + 2)) r[8*k +: 8] = d[55 - 8*k -: 8];
        return r;
    endfunction

    // Frame expected to be forwarded; checks count, opcode, length, operands.
    task automatic expect_fwd(input string req, input logic [63:0] d, input int n,
                              input bit q, input bit m3);
        int n0;
        n0 = ncmd;
        send(d, n, q, m3);
        chk(ncmd == n0 + 1, req, "strobe count", 64'(ncmd - n0), 64'd1);
        chk(m_op == d[63:56], req, "opcode", 64'(m_op), 64'(d[63:56]));
        chk(m_bits == 8'(n), req, "bit count", 64'(m_bits), 64'(n));
        chk(m_ops == exp_ops(d, n), req, "operands", 64'(m_ops), 64'(exp_ops(d, n)));
    endtask

    task automatic expect_none(input string req, input logic [63:0] d, input int n,
                               input bit q);
        int n0;
        n0 = ncmd;
        send(d, n, q, 1'b0);
        chk(ncmd == n0, req, "no strobe", 64'(ncmd - n0), 64'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n0;
        wait_n(5);
        rst = 1'b0;
        wait_n(2);
        // R1 reset state
        chk(cmd_valid == 1'b0, "R1", "cmd_valid", 64'(cmd_valid), 64'd0);
        chk(qpi_mode == 1'b0, "R1", "qpi_mode", 64'(qpi_mode), 64'd0);
        chk(reset_busy == 1'b0, "R1", "reset_busy", 64'(reset_busy), 64'd0);

        // R2 clocks while chip select stays low from reset
        n0 = ncmd;
        for (int i = 0; i < 16; i++) begin
            bus_io = {3'b000, pat(8'h03)[63 - i]};
            wait_n(HALF); bus_sclk = 1'b1; wait_n(HALF); bus_sclk = 1'b0;
        end
        bus_cs_n = 1'b1;
        wait_n(20);
        chk(ncmd == n0, "R2", "unarmed frame", 64'(ncmd - n0), 64'd0);

        // R3 R11 single-line read sweep over every length
        for (int n = 8; n <= 48; n++) expect_fwd("R3", pat(8'h03), n, 1'b0, 1'b0);
        // R11 short frames
        for (int n = 1; n <= 7; n++) expect_none("R11", pat(8'h03), n, 1'b0);

        // R8 write-type sweep
        for (int n = 8; n <= 40; n++) begin
            if (n % 8 == 0) expect_fwd("R8", pat(8'h02), n, 1'b0, 1'b0);
            else            expect_none("R8", pat(8'h02), n, 1'b0);
        end
        expect_none("R8", pat(8'hD8), 31, 1'b0);
        expect_fwd("R8", pat(8'hD8), 32, 1'b0, 1'b0);

        // R5 mode 3 framing
        expect_fwd("R5", pat(8'h0B), 32, 1'b0, 1'b1);
        expect_fwd("R5", pat(8'h0B), 19, 1'b0, 1'b1);

        // R6 enter four-line mode
        quad_en = 1'b0;
        expect_none("R6", pat(8'h38), 8, 1'b0);
        chk(qpi_mode == 1'b0, "R6", "qe=0 ignored", 64'(qpi_mode), 64'd0);
        quad_en = 1'b1;
        expect_none("R6", pat(8'h38), 9, 1'b0);
        chk(qpi_mode == 1'b0, "R6", "unaligned ignored", 64'(qpi_mode), 64'd0);
        expect_none("R6", pat(8'h38), 8, 1'b0);
        chk(qpi_mode == 1'b1, "R6", "qpi entered", 64'(qpi_mode), 64'd1);

        // R4 four-line sweep
        for (int n = 8; n <= 48; n += 4) expect_fwd("R4", pat(8'hEB), n, 1'b1, 1'b0);
        expect_none("R8", pat(8'h02), 36, 1'b1);
        expect_fwd("R8", pat(8'h02), 40, 1'b1, 1'b0);

        // R9 R10 software reset from four-line mode
        expect_none("R9", pat(8'h66), 8, 1'b1);
        busy_cycles = 0;
        expect_none("R9", pat(8'h99), 8, 1'b1);
        chk(qpi_mode == 1'b0, "R9", "mode after reset", 64'(qpi_mode), 64'd0);
        expect_none("R10", pat(8'h03), 16, 1'b0);
        wait_n(60);
        chk(busy_cycles == RST_CYC, "R9", "busy length", 64'(busy_cycles), 64'(RST_CYC));
        expect_fwd("R10", pat(8'h03), 16, 1'b0, 1'b0);

        // R9 reset without arm, and arm cancelled by another command
        busy_cycles = 0;
        expect_none("R9", pat(8'h99), 8, 1'b0);
        expect_none("R9", pat(8'h66), 8, 1'b0);
        expect_fwd("R9", pat(8'h05), 16, 1'b0, 1'b0);
        expect_none("R9", pat(8'h99), 8, 1'b0);
        wait_n(10);
        chk(busy_cycles == 0, "R9", "no reset", 64'(busy_cycles), 64'd0);

        // R7 leave four-line mode
        expect_none("R7", pat(8'h38), 8, 1'b0);
        chk(qpi_mode == 1'b1, "R7", "qpi before exit", 64'(qpi_mode), 64'd1);
        expect_none("R7", pat(8'hFF), 8, 1'b1);
        chk(qpi_mode == 1'b0, "R7", "qpi after exit", 64'(qpi_mode), 64'd0);
        expect_fwd("R7", pat(8'h03), 24, 1'b0, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule